// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind a two-wire serial memory protocol engine and takes over the data phase of a write access. When the engine has received the word address, it loads that address. Each data byte received after that is placed in a one-page buffer at the current in-page offset, and the offset advances. The page number never changes during an access, so the offset wraps inside the page and any bytes beyond one page overwrite earlier bytes of the same access. A mask records which buffer positions hold new data.

On the stop that closes the access, the block raises `busy` for a fixed number of system clocks, as long as at least one data byte arrived. During that time it writes every masked byte into the external memory array through a simple write port, in ascending offset order. While `busy` is high the block ignores all of its bus-side inputs. The protocol engine uses `busy` to withhold acknowledges, which lets a master poll for completion. A stop that follows only the address starts no write cycle.

The busy length stands for the worst-case internal write time: 10 ms, expressed as `BUSY_CYCLES` clocks (1,000,000 at 100 MHz). If the parameter is shorter than one page of clocks, the busy period is stretched to one page.

Top module: `page_write_commit`

## Requirements
- R1: After reset, `busy` is 0, `memWe` is 0 and `curAddr` is 0.
- R2: An `addrLoad` pulse sets `curAddr` to `loadAddr` on the next clock. Each accepted data byte adds one to the low `OFFS_W` bits of `curAddr` and leaves the upper page bits unchanged.
- R3: The byte that follows offset `2^OFFS_W-1` goes to offset 0 of the same page. When more than one page of bytes is sent, the array receives the last value written to each offset.
- R4: A `stopIn` pulse after at least one data byte makes `busy` 1 on the next clock. `busy` then stays 1 for exactly max(`BUSY_CYCLES`, `2^OFFS_W`) cycles.
- R5: A `stopIn` that follows an address with no data bytes leaves `busy` at 0 and produces no array writes.
- R6: During the busy period, each written offset produces exactly one `memWe` pulse. The pulse for offset k falls in busy cycle k (counting from 0), so pulses come in ascending order. `memAddr` carries the access page and offset k, and `memData` carries the byte held there. `memWe` is never 1 outside `busy`.
- R7: While `busy` is 1, `addrLoad`, `dataValid` and `stopIn` have no effect. `curAddr`, the committed data and the busy length are unchanged by them.
- R8: When the commit ends, the written-position mask clears, so a later access writes only its own positions.
- R9: After the commit, `curAddr` equals the page followed by one past the last written offset, wrapped within the page.
- R10: Data bytes and stops that arrive before any address load are ignored: no busy period, no writes, and `curAddr` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrLoad | input | 1 | Strobe: the word address of a new write access is complete |
| loadAddr | input | ADDR_W | Start address (page bits above offset bits) |
| dataValid | input | 1 | Strobe: one data byte received |
| dataByte | input | 8 | Received data byte |
| stopIn | input | 1 | Strobe: stop condition seen on the bus |
| busy | output | 1 | Self-timed write cycle in progress; bus inputs ignored |
| curAddr | output | ADDR_W | Shared address counter (page, offset) |
| memWe | output | 1 | Array write enable |
| memAddr | output | ADDR_W | Array write address |
| memData | output | 8 | Array write data |

## Verification
`curAddr` updates one clock after an address load or a data byte. `busy` rises one clock after the stop strobe. The write for offset k appears k clocks after `busy` rises, and `busy` falls `BUSY_CYCLES` clocks after it rose. The bench drives its inputs on falling edges and samples on the next falling edge, so each result is read half a cycle after the edge that produced it. A falling-edge monitor counts busy cycles and writes, checks each write's offset against its position within the busy period, and builds a copy of the array. After each access ends, that copy is compared with a model computed in the bench from the page, the start offset and the byte count.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  // Strobes from the control FSM to the datapath, valid for one cycle.
  typedef struct packed {
    logic ldAddr;    // load page and offset from loadAddr
    logic wrByte;    // store dataByte at current offset, advance offset
    logic commitOn;  // commit scan active, scanIdx valid
    logic clrMask;   // last busy cycle: clear written-position mask
  } pwc_strobe_t;
endpackage

// File: rtl/pwc_ctrl.sv
module pwc_ctrl
  import pwc_pkg::*;
#(
  parameter int OFFS_W      = 8,
  parameter int BUSY_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic              dataValid,
  input  logic              stopIn,
  input  logic              maskAny,
  output pwc_strobe_t       strobes,
  output logic [OFFS_W-1:0] scanIdx,
  output logic              busy
);
  localparam int PAGE_BYTES = 1 << OFFS_W;
  localparam int BUSY_LEN   = (BUSY_CYCLES < PAGE_BYTES) ? PAGE_BYTES : BUSY_CYCLES;
  localparam int CNT_W      = $clog2(BUSY_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BUSY_LEN - 1);
  localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_BUSY} state_t;

  state_t           state;
  logic [CNT_W-1:0] busyCnt;

  assign busy    = (state == ST_BUSY);
  assign scanIdx = busyCnt[OFFS_W-1:0];

  always_comb begin
    strobes = '0;
    case (state)
      ST_IDLE: strobes.ldAddr = addrLoad;
      ST_FILL: begin
        strobes.ldAddr = addrLoad;
        strobes.wrByte = dataValid && !addrLoad;
      end
      ST_BUSY: begin
        strobes.commitOn = (busyCnt < PAGE_CNT);
        strobes.clrMask  = (busyCnt == LAST_CNT);
      end
      default: strobes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busyCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (addrLoad) state <= ST_FILL;
        ST_FILL: begin
          if (!addrLoad && stopIn) begin
            state   <= maskAny ? ST_BUSY : ST_IDLE;
            busyCnt <= '0;
          end
        end
        ST_BUSY: begin
          if (busyCnt == LAST_CNT) begin
            state   <= ST_IDLE;
            busyCnt <= '0;
          end else begin
            busyCnt <= busyCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopIn)); // R4
  AST_NO_BUSY_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL && stopIn && !addrLoad && !maskAny) |=> !busy); // R5
  AST_DEAF_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strobes.ldAddr || strobes.wrByte)); // R7
endmodule

// File: rtl/pwc_datapath.sv
module pwc_datapath
  import pwc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int OFFS_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwc_strobe_t       strobes,
  input  logic [OFFS_W-1:0] scanIdx,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        dataByte,
  output logic              maskAny,
  output logic [ADDR_W-1:0] curAddr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);
  localparam int PAGE_W     = ADDR_W - OFFS_W;
  localparam int PAGE_BYTES = 1 << OFFS_W;

  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] fillMask;
  logic [PAGE_W-1:0]     pageReg;
  logic [OFFS_W-1:0]     offReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg  <= '0;
      offReg   <= '0;
      fillMask <= '0;
    end else begin
      if (strobes.ldAddr) begin
        pageReg <= loadAddr[ADDR_W-1:OFFS_W];
        offReg  <= loadAddr[OFFS_W-1:0];
      end else if (strobes.wrByte) begin
        offReg           <= offReg + 1'b1;
        fillMask[offReg] <= 1'b1;
      end
      if (strobes.clrMask) fillMask <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.wrByte) pageBuf[offReg] <= dataByte;
  end

  assign maskAny = |fillMask;
  assign curAddr = {pageReg, offReg};
  assign memWe   = strobes.commitOn && fillMask[scanIdx];
  assign memAddr = {pageReg, scanIdx};
  assign memData = pageBuf[scanIdx];

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrByte |=> $stable(pageReg)); // R2
  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrMask |=> !maskAny); // R8
endmodule

// File: rtl/page_write_commit.sv
module page_write_commit
  import pwc_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int OFFS_W      = 8,
  parameter int BUSY_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              dataValid,
  input  logic [7:0]        dataByte,
  input  logic              stopIn,
  output logic              busy,
  output logic [ADDR_W-1:0] curAddr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);
  pwc_strobe_t       strobes;
  logic [OFFS_W-1:0] scanIdx;
  logic              maskAny;

  pwc_ctrl #(.OFFS_W(OFFS_W), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .dataValid(dataValid),
    .stopIn(stopIn), .maskAny(maskAny), .strobes(strobes),
    .scanIdx(scanIdx), .busy(busy)
  );

  pwc_datapath #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .scanIdx(scanIdx),
    .loadAddr(loadAddr), .dataByte(dataByte), .maskAny(maskAny),
    .curAddr(curAddr), .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy); // R6
  AST_WE_SAME_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[ADDR_W-1:OFFS_W] == curAddr[ADDR_W-1:OFFS_W])); // R6
endmodule

// File: tb/page_write_commit_tb.sv
module page_write_commit_tb;
  localparam int AW = 6;
  localparam int OW = 3;
  localparam int PB = 1 << OW;
  localparam int BUSY = 12;
  localparam int MEMN = 1 << AW;

  logic clk = 0;
  logic rstN = 0;
  logic addrLoad = 0, dataValid = 0, stopIn = 0;
  logic [AW-1:0] loadAddr = '0;
  logic [7:0] dataByte = '0;
  logic busy, memWe;
  logic [AW-1:0] curAddr, memAddr;
  logic [7:0] memData;

  page_write_commit #(.ADDR_W(AW), .OFFS_W(OW), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .loadAddr(loadAddr),
    .dataValid(dataValid), .dataByte(dataByte), .stopIn(stopIn),
    .busy(busy), .curAddr(curAddr), .memWe(memWe), .memAddr(memAddr),
    .memData(memData)
  );

  always #5 clk = ~clk;

  int nChk = 0, nBad = 0;
  logic [7:0] expMem [MEMN];
  logic [7:0] seenMem [MEMN];
  int totalBusy = 0, totalWrites = 0, orderBad = 0, busyIdx = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor on falling edges: builds array copy, counts busy cycles and writes.
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) begin
        if (memWe) begin
          seenMem[memAddr] = memData;
          totalWrites++;
          if (busyIdx >= PB || int'(memAddr[OW-1:0]) != busyIdx) orderBad++;
        end
        busyIdx++;
        totalBusy++;
      end else begin
        if (memWe) orderBad++;
        busyIdx = 0;
      end
    end
  end

  function automatic int memDiffs();
    int d = 0;
    for (int k = 0; k < MEMN; k++) if (seenMem[k] !== expMem[k]) d++;
    return d;
  endfunction

  task automatic doAccess(input int page, input int start, input int n, input int trial,
                          input bit poke);
    int b0 = totalBusy, w0 = totalWrites, o0 = orderBad;
    int expW = (n < PB) ? n : PB;
    logic [AW-1:0] a = AW'(page * PB + start);
    @(negedge clk);
    addrLoad = 1; loadAddr = a;
    @(negedge clk);
    addrLoad = 0;
    chk(curAddr == a, "R2 load", curAddr, a);
    for (int i = 0; i < n; i++) begin
      dataByte = 8'((page * 37 + i * 13 + trial * 5 + start) & 8'hFF);
      expMem[page * PB + ((start + i) % PB)] = dataByte;
      dataValid = 1;
      @(negedge clk);
    end
    dataValid = 0;
    if (n > 0) chk(curAddr == AW'(page * PB + (start + n) % PB), "R2 advance",
                   curAddr, page * PB + (start + n) % PB);
    stopIn = 1;
    @(negedge clk);
    stopIn = 0;
    chk(busy == (n > 0), (n > 0) ? "R4 busy rise" : "R5 no busy", busy, n > 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      addrLoad = 1; loadAddr = AW'(MEMN - 1); dataValid = 1; dataByte = 8'hEE; stopIn = 1;
      @(negedge clk);
      addrLoad = 0; dataValid = 0; stopIn = 0;
    end
    repeat (BUSY + 4) @(negedge clk);
    chk(totalBusy - b0 == ((n > 0) ? BUSY : 0), poke ? "R7 busy len" : "R4 busy len",
        totalBusy - b0, (n > 0) ? BUSY : 0);
    chk(totalWrites - w0 == expW, "R6 R8 write count", totalWrites - w0, expW);
    chk(orderBad == o0, "R6 order", orderBad - o0, 0);
    chk(memDiffs() == 0, poke ? "R7 data" : "R3 array contents", memDiffs(), 0);
    chk(curAddr == AW'(page * PB + (start + n) % PB), poke ? "R7 addr" : "R9 final addr",
        curAddr, page * PB + (start + n) % PB);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    for (int k = 0; k < MEMN; k++) begin
      expMem[k] = '0;
      seenMem[k] = '0;
    end
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(memWe == 0, "R1 memWe", memWe, 0);
    chk(curAddr == 0, "R1 curAddr", curAddr, 0);
    rstN = 1;
    @(negedge clk);
    // R10: data and stop with no address loaded
    dataValid = 1; dataByte = 8'h5A;
    @(negedge clk);
    dataValid = 0; stopIn = 1;
    @(negedge clk);
    stopIn = 0;
    repeat (BUSY + 2) @(negedge clk);
    chk(totalBusy == 0, "R10 no busy", totalBusy, 0);
    chk(totalWrites == 0, "R10 no writes", totalWrites, 0);
    chk(curAddr == 0, "R10 curAddr", curAddr, 0);
    // Sweep pages, start offsets and lengths (0, partial, full, wrapped)
    begin
      int trial = 0;
      for (int p = 0; p < MEMN / PB; p += 3) begin
        for (int s = 0; s < PB; s++) begin
          doAccess(p, s, 0, trial, 0);
          doAccess(p, s, 1, trial, 0);
          doAccess(p, s, 3, trial, 0);
          doAccess(p, s, PB, trial, 0);
          doAccess(p, s, PB + 3, trial, 0);
          trial++;
        end
      end
      // R7: inputs poked during busy
      doAccess(3, 2, 4, trial, 1);
      doAccess(5, 6, PB + 1, trial + 1, 1);
    end
    @(negedge clk);
    chk(busy == 0, "R7 idle after poke", busy, 0);
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule